// File: doc/BRIEF.md
# UDP Command Frame Filter

This block watches received Ethernet frames as they stream past, one byte per beat, and decides for each frame whether it carries a valid lamp command. A frame is valid when its reported length is large enough, its EtherType field marks a type value and not a length, its IP protocol byte says UDP, and the byte that holds the command has actually arrived. For a valid frame, one bit of the command byte is copied into a sticky control output that drives the lamp.

The parser keeps no copy of the frame. It counts byte positions, keeps only the few bytes it needs, and gives its verdict when the last byte of the frame arrives. Every frame that reaches its end beat produces exactly one accept or reject pulse in the next cycle. A start-of-frame beat always restarts parsing. Bytes that arrive outside a frame are ignored.

Top module: `udp_cmd_filter`

## Requirements
- R1: After reset, `ctrl_o`, `accept_o` and `reject_o` are all 0.
- R2: A frame is accepted only if the `frame_len` value sampled on its start beat is greater than 42. A length of 43 can pass and a length of 42 is rejected.
- R3: The EtherType is byte 12 (high) joined with byte 13 (low), where byte 0 is the start beat. A frame is accepted only if this value is 1536 (0x0600) or more. 0x05FF is rejected, even though its swapped byte order would pass.
- R4: A frame is accepted only if byte 23 equals 0x11.
- R5: When a frame is accepted, `ctrl_o` takes bit 0 of byte 42 in the cycle after the end beat. The other bits of byte 42 have no effect.
- R6: A rejected frame leaves `ctrl_o` unchanged. `ctrl_o` changes only in a cycle where `accept_o` is high.
- R7: A frame whose end beat comes before byte 42 is rejected. This includes a one-beat frame with start and end on the same beat.
- R8: Each end beat that closes a frame gives exactly one cycle of `accept_o` or `reject_o`, in the cycle right after that beat. The two are never high together, and neither is high at any other time.
- R9: Beats with `in_valid` low do not advance the byte position. A start beat in the middle of a frame restarts parsing at byte 0. Valid beats outside a frame, including stray end beats, cause no pulse and no change of `ctrl_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; the block releases it synchronously |
| in_valid | input | 1 | The byte on `in_data` is valid in this cycle |
| in_sof | input | 1 | This valid beat is byte 0 of a frame |
| in_eof | input | 1 | This valid beat is the last byte of a frame |
| in_data | input | 8 | Frame byte |
| frame_len | input | LEN_W (16) | Frame length in bytes; sampled on the start beat |
| ctrl_o | output | 1 | Latched lamp control bit |
| accept_o | output | 1 | One-cycle pulse: the frame that just ended was accepted |
| reject_o | output | 1 | One-cycle pulse: the frame that just ended was rejected |

## Verification
A wrong byte position or a stale captured byte cannot be seen at the ports until the end beat of the frame. It then shows, one cycle after that beat, as a pulse of the wrong polarity or a wrong `ctrl_o` value. The test frames therefore put the decisive byte at each checked offset, and at each threshold one step on either side. A frame-tracking state that fails to clear after the end beat shows up as pulses after stray end beats, or as a wrong verdict on the frame after a restart. Both are checked in the cycle after the beat concerned.

// File: rtl/udp_filt_pkg.sv
`timescale 1ns/1ps
package udp_filt_pkg;
  // verdict registered one cycle after the closing beat of a frame
  typedef enum logic [1:0] {
    VERD_NONE   = 2'd0,
    VERD_ACCEPT = 2'd1,
    VERD_REJECT = 2'd2
  } verdict_e;

  localparam int BYTE_W = 8;
endpackage

// File: rtl/ucf_pos_track.sv
`timescale 1ns/1ps
module ucf_pos_track #(
  parameter int CNT_W = 6,
  parameter int LAST  = 43
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             beat_valid,
  input  logic             beat_sof,
  input  logic             beat_eof,
  output logic [CNT_W-1:0] cur_pos,
  output logic             live
);
  localparam logic [CNT_W-1:0] LAST_C = CNT_W'(LAST);

  logic [CNT_W-1:0] pos_q, pos_d;
  logic             in_frame_q, in_frame_d;

  // byte index of the current beat; a start beat is always byte 0
  always_comb begin
    cur_pos = beat_sof ? '0 : pos_q;
    live    = beat_valid && (beat_sof || in_frame_q);
  end

  always_comb begin
    pos_d      = pos_q;
    in_frame_d = in_frame_q;
    if (live) begin
      pos_d      = (cur_pos == LAST_C) ? cur_pos : cur_pos + CNT_W'(1);
      in_frame_d = !beat_eof;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q      <= '0;
      in_frame_q <= 1'b0;
    end else if (live) begin
      pos_q      <= pos_d;
      in_frame_q <= in_frame_d;
    end
  end
endmodule

// File: rtl/ucf_field_grab.sv
`timescale 1ns/1ps
module ucf_field_grab #(
  parameter int CNT_W = 6,
  parameter int POS   = 12
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              live,
  input  logic                              beat_sof,
  input  logic [CNT_W-1:0]                  cur_pos,
  input  logic [udp_filt_pkg::BYTE_W-1:0]   data,
  output logic [udp_filt_pkg::BYTE_W-1:0]   byte_view,
  output logic                              seen_view
);
  localparam logic [CNT_W-1:0] POS_C = CNT_W'(POS);

  logic [udp_filt_pkg::BYTE_W-1:0] byte_q, byte_d;
  logic                            seen_q, seen_d;
  logic                            hit;
  logic                            grab_en;

  always_comb begin
    hit       = live && (cur_pos == POS_C);
    // current beat overrides the stored copy so the closing beat is usable
    byte_view = hit ? data : byte_q;
    seen_view = hit || (seen_q && !beat_sof);
    byte_d    = data;
    seen_d    = seen_view;
    grab_en   = live;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q <= 1'b0;
    end else if (grab_en) begin
      seen_q <= seen_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      byte_q <= '0;
    end else if (hit) begin
      byte_q <= byte_d;
    end
  end
endmodule

// File: rtl/ucf_verdict.sv
`timescale 1ns/1ps
module ucf_verdict #(
  parameter int          LEN_W     = 16,
  parameter int          LEN_FLOOR = 42,
  parameter int          MIN_ETYPE = 1536,
  parameter logic [7:0]  PROTO_VAL = 8'h11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             done,
  input  logic [LEN_W-1:0] len_view,
  input  logic [15:0]      etype,
  input  logic [7:0]       proto,
  input  logic             all_seen,
  input  logic             cmd_bit,
  output logic             ctrl_o,
  output logic             accept_o,
  output logic             reject_o
);
  import udp_filt_pkg::*;

  verdict_e verd_q, verd_d;
  logic     ctrl_q, ctrl_d;
  logic     pass;

  always_comb begin
    pass   = (len_view > LEN_W'(LEN_FLOOR)) &&
             (etype >= 16'(MIN_ETYPE)) &&
             (proto == PROTO_VAL) &&
             all_seen;
    verd_d = VERD_NONE;
    ctrl_d = ctrl_q;
    if (done) begin
      verd_d = pass ? VERD_ACCEPT : VERD_REJECT;
      if (pass) ctrl_d = cmd_bit;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      verd_q <= VERD_NONE;
      ctrl_q <= 1'b0;
    end else begin
      verd_q <= verd_d;
      ctrl_q <= ctrl_d;
    end
  end

  assign ctrl_o   = ctrl_q;
  assign accept_o = (verd_q == VERD_ACCEPT);
  assign reject_o = (verd_q == VERD_REJECT);
endmodule

// File: rtl/udp_cmd_filter.sv
`timescale 1ns/1ps
module udp_cmd_filter #(
  parameter int         LEN_W        = 16,
  parameter int         ETYPE_HI_POS = 12,
  parameter int         PROTO_POS    = 23,
  parameter int         CMD_POS      = 42,
  parameter int         CMD_BIT      = 0,
  parameter int         LEN_FLOOR    = 42,
  parameter int         MIN_ETYPE    = 1536,
  parameter logic [7:0] PROTO_VAL    = 8'h11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             in_sof,
  input  logic             in_eof,
  input  logic [7:0]       in_data,
  input  logic [LEN_W-1:0] frame_len,
  output logic             ctrl_o,
  output logic             accept_o,
  output logic             reject_o
);
  localparam int LAST   = CMD_POS + 1;
  localparam int CNT_W  = $clog2(LAST + 1);
  localparam int N_GRAB = 4;
  localparam int GRAB_POS [N_GRAB] = '{ETYPE_HI_POS, ETYPE_HI_POS + 1, PROTO_POS, CMD_POS};

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_n_int;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1];

  logic [CNT_W-1:0] cur_pos;
  logic             live;

  ucf_pos_track #(.CNT_W(CNT_W), .LAST(LAST)) i_pos (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .beat_valid(in_valid),
    .beat_sof  (in_sof),
    .beat_eof  (in_eof),
    .cur_pos   (cur_pos),
    .live      (live)
  );

  logic [7:0]        grab_byte [N_GRAB];
  logic [N_GRAB-1:0] grab_seen;

  for (genvar g = 0; g < N_GRAB; g++) begin : g_grab
    ucf_field_grab #(.CNT_W(CNT_W), .POS(GRAB_POS[g])) i_grab (
      .clk      (clk),
      .rst_n    (rst_n_int),
      .live     (live),
      .beat_sof (in_sof),
      .cur_pos  (cur_pos),
      .data     (in_data),
      .byte_view(grab_byte[g]),
      .seen_view(grab_seen[g])
    );
  end

  // frame length is sampled on the start beat
  logic [LEN_W-1:0] len_q;
  logic [LEN_W-1:0] len_view;
  logic             len_en;
  always_comb begin
    len_en   = live && in_sof;
    len_view = in_sof ? frame_len : len_q;
  end
  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int)  len_q <= '0;
    else if (len_en) len_q <= frame_len;
  end

  logic [7:0] cmd_byte;
  logic       cmd_unused_xor;
  assign cmd_byte       = grab_byte[3];
  assign cmd_unused_xor = ^cmd_byte;

  ucf_verdict #(
    .LEN_W(LEN_W), .LEN_FLOOR(LEN_FLOOR),
    .MIN_ETYPE(MIN_ETYPE), .PROTO_VAL(PROTO_VAL)
  ) i_verdict (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .done    (live && in_eof),
    .len_view(len_view),
    .etype   ({grab_byte[0], grab_byte[1]}),
    .proto   (grab_byte[2]),
    .all_seen(&grab_seen),
    .cmd_bit (cmd_byte[CMD_BIT]),
    .ctrl_o  (ctrl_o),
    .accept_o(accept_o),
    .reject_o(reject_o)
  );
endmodule

// File: rtl/udp_cmd_filter_chk.sv
`timescale 1ns/1ps
module udp_cmd_filter_chk #(
  parameter int LEN_W     = 16,
  parameter int LEN_FLOOR = 42
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_sof,
  input logic             in_eof,
  input logic [LEN_W-1:0] frame_len,
  input logic             ctrl_o,
  input logic             accept_o,
  input logic             reject_o
);
  // independent record of the length seen on the latest start beat
  logic [LEN_W-1:0] len_seen_q;
  logic [LEN_W-1:0] len_at_end_q;
  logic [LEN_W-1:0] len_now;
  assign len_now = in_sof ? frame_len : len_seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_seen_q   <= '0;
      len_at_end_q <= '0;
    end else if (in_valid) begin
      if (in_sof) len_seen_q <= frame_len;
      if (in_eof) len_at_end_q <= len_now;
    end
  end

  // R8
  pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({accept_o, reject_o}));

  // R8
  pulse_after_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept_o || reject_o) |-> $past(in_valid && in_eof));

  // R6
  ctrl_hold_on_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reject_o |-> $stable(ctrl_o));

  // R6
  ctrl_change_needs_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ctrl_o) |-> accept_o);

  // R2
  accept_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept_o |-> (len_at_end_q > LEN_W'(LEN_FLOOR)));
endmodule

bind udp_cmd_filter udp_cmd_filter_chk #(.LEN_W(LEN_W), .LEN_FLOOR(LEN_FLOOR)) i_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .in_sof   (in_sof),
  .in_eof   (in_eof),
  .frame_len(frame_len),
  .ctrl_o   (ctrl_o),
  .accept_o (accept_o),
  .reject_o (reject_o)
);

// File: tb/test_udp_cmd_filter.sv
`timescale 1ns/1ps
module test_udp_cmd_filter;
  logic        clk;
  logic        rst_n;
  logic        in_valid, in_sof, in_eof;
  logic [7:0]  in_data;
  logic [15:0] frame_len;
  logic        ctrl_o, accept_o, reject_o;

  int n_checks = 0;
  int n_fail   = 0;

  udp_cmd_filter i_udp_cmd_filter (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof),
    .in_eof(in_eof), .in_data(in_data), .frame_len(frame_len),
    .ctrl_o(ctrl_o), .accept_o(accept_o), .reject_o(reject_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // {len16, nbytes8, etype16, proto8, cmd8, exp_accept1, exp_ctrl1}
  localparam int NV = 11;
  localparam logic [57:0] VEC [NV] = '{
    {16'd60,   8'd60, 16'h0800, 8'h11, 8'h01, 1'b1, 1'b1}, // R5 accept, ctrl 1
    {16'd60,   8'd60, 16'h0800, 8'h06, 8'h00, 1'b0, 1'b1}, // R4 wrong protocol
    {16'd42,   8'd43, 16'h0800, 8'h11, 8'h00, 1'b0, 1'b1}, // R2 length 42
    {16'd43,   8'd43, 16'h0600, 8'h11, 8'h00, 1'b1, 1'b0}, // R2 R3 both at boundary
    {16'd60,   8'd60, 16'h05FF, 8'h11, 8'h01, 1'b0, 1'b0}, // R3 below threshold, order
    {16'd60,   8'd30, 16'h0800, 8'h11, 8'h01, 1'b0, 1'b0}, // R7 short
    {16'd60,   8'd42, 16'h0800, 8'h11, 8'h01, 1'b0, 1'b0}, // R7 ends at byte 41
    {16'd64,   8'd64, 16'h86DD, 8'h11, 8'hFE, 1'b1, 1'b0}, // R5 only bit 0
    {16'd64,   8'd64, 16'hFFFF, 8'h11, 8'h03, 1'b1, 1'b1}, // R3 top value
    {16'd1500, 8'd60, 16'h0800, 8'h11, 8'h00, 1'b1, 1'b0}, // R2 large length
    {16'd60,   8'd60, 16'h0800, 8'h12, 8'h01, 1'b0, 1'b0}  // R4 off by one
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] frame_byte(input int i, input logic [15:0] et,
                                            input logic [7:0] pr, input logic [7:0] cm);
    if (i == 12) return et[15:8];
    if (i == 13) return et[7:0];
    if (i == 23) return pr;
    if (i == 42) return cm;
    return 8'(i * 7 + 3);
  endfunction

  task automatic idle();
    in_valid = 0; in_sof = 0; in_eof = 0; in_data = 0;
  endtask

  // drives one frame; returns at the negedge after the closing beat's edge
  task automatic send_frame(input logic [15:0] len, input int n, input logic [15:0] et,
                            input logic [7:0] pr, input logic [7:0] cm, input int gap);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid  = 1;
      in_sof    = (i == 0);
      in_eof    = (i == n - 1);
      in_data   = frame_byte(i, et, pr, cm);
      frame_len = (i == 0) ? len : 16'hDEAD;
      if (gap > 0 && i < n - 1) begin
        for (int k = 0; k < gap; k++) begin
          @(negedge clk);
          idle();
          in_data = 8'h11;
        end
      end
    end
    @(negedge clk);
    idle();
  endtask

  task automatic do_reset();
    idle();
    frame_len = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    do_reset();
    // R1 reset state
    check(ctrl_o == 0 && accept_o == 0 && reject_o == 0, "R1",
          {ctrl_o, accept_o, reject_o}, 0);

    for (int v = 0; v < NV; v++) begin
      send_frame(VEC[v][57:42], int'(VEC[v][41:34]), VEC[v][33:18],
                 VEC[v][17:10], VEC[v][9:2], 0);
      // R2/R3/R4/R7: verdict; R8: exactly one pulse
      check(accept_o == VEC[v][1] && reject_o == !VEC[v][1], "R8 verdict",
            {accept_o, reject_o}, {VEC[v][1], !VEC[v][1]});
      // R5/R6 control bit
      check(ctrl_o == VEC[v][0], "R5 ctrl", ctrl_o, VEC[v][0]);
      @(negedge clk);
      // R8 single-cycle pulse
      check(!accept_o && !reject_o, "R8 pulse length", {accept_o, reject_o}, 0);
    end

    // R9 gapped frame still parses at the right offsets
    send_frame(16'd60, 60, 16'h0800, 8'h11, 8'h01, 2);
    check(accept_o && ctrl_o, "R9 gaps", {accept_o, ctrl_o}, 3);

    send_frame(16'd60, 60, 16'h0800, 8'h11, 8'h00, 0);
    check(accept_o && !ctrl_o, "R5 clear", {accept_o, ctrl_o}, 2);

    // R9 restart: partial frame with bad protocol, then a new start beat
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      in_valid = 1; in_sof = (i == 0); in_eof = 0;
      in_data = frame_byte(i, 16'h0100, 8'h06, 8'h00);
      frame_len = (i == 0) ? 16'd10 : 16'd0;
    end
    send_frame(16'd50, 50, 16'h0800, 8'h11, 8'h01, 0);
    check(accept_o && ctrl_o, "R9 restart", {accept_o, ctrl_o}, 3);
    @(negedge clk);

    // R9 stray bytes outside any frame, with end beats among them
    begin
      int bad = 0;
      for (int i = 0; i < 50; i++) begin
        in_valid = 1; in_sof = 0; in_eof = (i % 9 == 8);
        in_data = 8'h10;
        @(negedge clk);
        if (accept_o || reject_o || !ctrl_o) bad++;
      end
      idle();
      @(negedge clk);
      if (accept_o || reject_o || !ctrl_o) bad++;
      check(bad == 0, "R9 stray", bad, 0);
    end

    // R7 one-beat frame
    send_frame(16'd60, 1, 16'h0800, 8'h11, 8'h00, 0);
    check(reject_o && !accept_o && ctrl_o, "R7 one beat",
          {accept_o, reject_o, ctrl_o}, 3);

    // R1 reset clears a set control bit
    @(negedge clk);
    do_reset();
    check(!ctrl_o && !accept_o && !reject_o, "R1 re-reset",
          {ctrl_o, accept_o, reject_o}, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 8);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule